// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Conversion Sequencer

This block is the digital control side of a successive-approximation analog-to-digital converter that serves eight analog inputs. Once it is started, it walks an inclusive range of channels in ascending order and wraps from channel 7 to channel 0 when the first channel is numbered above the last. For each channel it drives the input-select lines and holds the sample-and-hold gate open for a programmable number of cycles. It then runs one trial per result bit, most significant bit first. On each trial it sets the bit under trial in the DAC code and keeps that bit only if the comparator reports the held input as greater than the DAC level. Each trial lasts a programmable number of cycles. A result is 8 or 10 bits wide.

A conversion starts from a software start pulse or from one of two timer events, chosen by a selection field: a reload-timer output pulse or a free-running-timer zero-detect pulse. Each finished result leaves the block on a valid/ready stream. `res_valid_o` rises with the result and stays high, with data and channel number unchanged, until `res_ready_i` is seen high at a clock edge. The sequencer stalls while the result waits, and it starts the next channel's sample phase on the edge that accepts the current result. Each result also sets a sticky interrupt flag, and an enable input gates that flag onto the interrupt output. Configuration inputs must be held steady while `busy_o` is high.

The analog multiplexer, the sample-and-hold, the DAC and the comparator lie outside this block.

Top module: `sar_scan_ctrl`

## Requirements
- R1: A conversion scan starts on a `sw_start` pulse at any time the block is idle. `cfg_ext_sel` decides which timer events also start one: 2'b00 none, 2'b01 reload pulse only, 2'b10 zero-detect pulse only, 2'b11 either. A pulse from an event that is not selected leaves `busy_o` low.
- R2: Any start or timer pulse that arrives while `busy_o` is high is ignored. It adds no channels and does not restart the scan.
- R3: Channels are converted in ascending order from `cfg_first_ch` to `cfg_last_ch`, both inclusive, counting modulo 8. When first equals last, exactly one channel is converted. `ch_sel_o` and `res_ch_o` carry the channel currently being converted.
- R4: Each channel conversion opens with a sample phase. In that phase `sh_sample_o` is high for `cfg_smp_len`+1 cycles and `ch_sel_o` shows the channel.
- R5: A change on the analog input after the sample phase has ended has no effect on that channel's result.
- R6: After the sample phase there are 10 trials when `cfg_res10`=1 and 8 trials otherwise, each lasting `cfg_cmp_len`+1 cycles. `res_valid_o` rises (smp+1)+bits*(cmp+1) cycles after the start edge or the previous accepting edge.
- R7: A trial keeps its bit when `cmp_gt_i` is high during the trial's last cycle. The result is therefore the largest code whose DAC level lies strictly below the held input, or 0. In 8-bit mode the result sits in `res_data_o[7:0]` with bits [9:8] zero.
- R8: While `res_valid_o` is high and `res_ready_i` is low, `res_valid_o`, `res_data_o` and `res_ch_o` hold steady. The next channel starts only on the accepting edge.
- R9: `irq_flag_o` is set in the same cycle that a result becomes valid. It stays set until an `irq_clr` pulse clears it, and a set in the same cycle wins over the clear. `irq_o` equals `irq_flag_o` AND `irq_en`.
- R10: `busy_o` rises the cycle after an accepted trigger. It falls the cycle after the last channel's result is accepted. While idle, `sh_sample_o` and `res_valid_o` are low.
- R11: After reset, `busy_o`, `irq_flag_o`, `irq_o`, `sh_sample_o`, `res_valid_o` and `dac_code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_first_ch | input | 3 | First channel of the scan |
| cfg_last_ch | input | 3 | Last channel of the scan |
| cfg_res10 | input | 1 | 1 selects 10-bit results, 0 selects 8-bit |
| cfg_smp_len | input | 8 | Sample phase length minus one, in cycles |
| cfg_cmp_len | input | 4 | Per-bit trial length minus one, in cycles |
| cfg_ext_sel | input | 2 | Timer trigger selection (see R1) |
| sw_start | input | 1 | Software start pulse |
| tmr_reload_pulse | input | 1 | Reload-timer output pulse |
| tmr_zero_pulse | input | 1 | Free-running-timer zero-detect pulse |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the interrupt flag |
| busy_o | output | 1 | Scan in progress |
| irq_flag_o | output | 1 | Sticky result flag |
| irq_o | output | 1 | Interrupt request |
| ch_sel_o | output | 3 | Analog input select |
| sh_sample_o | output | 1 | Sample-and-hold gate (high = sampling) |
| dac_code_o | output | 10 | DAC code during trials, zero otherwise |
| cmp_gt_i | input | 1 | Comparator: held input above DAC level |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result accepted by the consumer |
| res_ch_o | output | 3 | Channel number of the result |
| res_data_o | output | 10 | Conversion result |

## Verification
A wrong bit index or a wrong keep decision in the trial engine appears as a wrong `res_data_o` value when the result becomes valid, which is at most one conversion length after the fault. A fault in one of the phase counters moves the rising edge of `sh_sample_o` or of `res_valid_o` by whole cycles, so a model that counts cycles exactly catches it on the first clock where the two disagree. Faults in the channel counter or in the busy and flag logic show on `ch_sel_o`, `busy_o` or `irq_flag_o` within one cycle of the bad edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_HOLD   = 2'd3
  } conv_ph_e;

  localparam logic [1:0] EXT_RELOAD_BIT = 2'b01;
  localparam logic [1:0] EXT_ZERO_BIT   = 2'b10;
endpackage

// File: rtl/sar_trig_sel.sv
module sar_trig_sel (
  input  logic       busy_i,
  input  logic [1:0] ext_sel_i,
  input  logic       sw_start_i,
  input  logic       reload_i,
  input  logic       zero_i,
  output logic       go_o
);
  import sar_seq_pkg::*;

  logic ext_hit;

  // a timer event counts only when its selection bit is set
  assign ext_hit = (reload_i && ((ext_sel_i & EXT_RELOAD_BIT) != 2'b00)) ||
                   (zero_i   && ((ext_sel_i & EXT_ZERO_BIT)   != 2'b00));

  // requests arriving during a scan are dropped
  assign go_o = !busy_i && (sw_start_i || ext_hit);
endmodule

// File: rtl/sar_chan_seq.sv
module sar_chan_seq #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            adv_i,
  input  logic [CH_W-1:0] first_i,
  input  logic [CH_W-1:0] last_i,
  output logic [CH_W-1:0] ch_o,
  output logic            at_end_o
);
  logic [CH_W-1:0] ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ch_q <= '0;
    else if (load_i) ch_q <= first_i;
    else if (adv_i)  ch_q <= ch_q + CH_W'(1);  // natural wrap past the top channel
  end

  assign ch_o     = ch_q;
  assign at_end_o = (ch_q == last_i);

  AST_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> !at_end_o);  // R3
endmodule

// File: rtl/sar_conv_core.sv
module sar_conv_core #(
  parameter int RES_W      = 10,
  parameter int RES_NARROW = 8,
  parameter int SMP_W      = 8,
  parameter int CMP_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             res10_i,
  input  logic [SMP_W-1:0] smp_len_i,
  input  logic [CMP_W-1:0] cmp_len_i,
  input  logic             cmp_gt_i,
  input  logic             res_ready_i,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic             res_valid_o,
  output logic [RES_W-1:0] res_data_o,
  output logic             done_o,
  output logic             hs_o
);
  import sar_seq_pkg::*;

  localparam int CNT_W = (SMP_W > CMP_W) ? SMP_W : CMP_W;
  localparam int IDX_W = $clog2(RES_W);

  conv_ph_e         ph;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bit_idx;
  logic [IDX_W-1:0] msb_idx;
  logic [RES_W-1:0] code;
  logic [RES_W-1:0] kept;
  logic             last_cyc;

  assign msb_idx  = res10_i ? IDX_W'(RES_W - 1) : IDX_W'(RES_NARROW - 1);
  assign last_cyc = (cnt == '0);

  // the comparator decides the bit under trial
  always_comb begin
    kept          = code;
    kept[bit_idx] = cmp_gt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      code    <= '0;
    end else if (start_i) begin
      ph   <= PH_SAMPLE;
      cnt  <= CNT_W'(smp_len_i);
      code <= '0;
    end else begin
      unique case (ph)
        PH_SAMPLE: begin
          if (last_cyc) begin
            ph      <= PH_TRIAL;
            bit_idx <= msb_idx;
            code    <= RES_W'(1) << msb_idx;
            cnt     <= CNT_W'(cmp_len_i);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_TRIAL: begin
          if (last_cyc) begin
            cnt <= CNT_W'(cmp_len_i);
            if (bit_idx == '0) begin
              ph   <= PH_HOLD;
              code <= kept;
            end else begin
              bit_idx <= bit_idx - IDX_W'(1);
              code    <= kept | (RES_W'(1) << (bit_idx - IDX_W'(1)));
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_HOLD: begin
          if (res_ready_i) ph <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign sample_o    = (ph == PH_SAMPLE);
  assign dac_code_o  = (ph == PH_TRIAL) ? code : '0;
  assign res_valid_o = (ph == PH_HOLD);
  assign res_data_o  = code;
  assign done_o      = (ph == PH_TRIAL) && last_cyc && (bit_idx == '0);
  assign hs_o        = (ph == PH_HOLD) && res_ready_i;

  AST_TRIAL_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_TRIAL) |-> code[bit_idx]);  // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i && !start_i) |=> (res_valid_o && $stable(res_data_o)));  // R8
  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res10_i) |-> (res_data_o[RES_W-1:RES_NARROW] == '0));  // R7
  AST_SAMPLE_BEFORE_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_TRIAL) && !$past(ph == PH_TRIAL)) |-> $past(sample_o));  // R4
endmodule

// File: rtl/sar_irq_flag.sv
module sar_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;  // a new result beats a clear in the same cycle
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && en_i;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);  // R9
endmodule

// File: rtl/sar_scan_ctrl.sv
module sar_scan_ctrl #(
  parameter int CH_W       = 3,
  parameter int RES_W      = 10,
  parameter int RES_NARROW = 8,
  parameter int SMP_W      = 8,
  parameter int CMP_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  cfg_first_ch,
  input  logic [CH_W-1:0]  cfg_last_ch,
  input  logic             cfg_res10,
  input  logic [SMP_W-1:0] cfg_smp_len,
  input  logic [CMP_W-1:0] cfg_cmp_len,
  input  logic [1:0]       cfg_ext_sel,
  input  logic             sw_start,
  input  logic             tmr_reload_pulse,
  input  logic             tmr_zero_pulse,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             busy_o,
  output logic             irq_flag_o,
  output logic             irq_o,
  output logic [CH_W-1:0]  ch_sel_o,
  output logic             sh_sample_o,
  output logic [RES_W-1:0] dac_code_o,
  input  logic             cmp_gt_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [CH_W-1:0]  res_ch_o,
  output logic [RES_W-1:0] res_data_o
);
  logic busy_q;
  logic go;
  logic hs;
  logic at_end;
  logic done;
  logic conv_start;
  logic ch_adv;
  logic [CH_W-1:0] ch;

  sar_trig_sel u_trig (
    .busy_i     (busy_q),
    .ext_sel_i  (cfg_ext_sel),
    .sw_start_i (sw_start),
    .reload_i   (tmr_reload_pulse),
    .zero_i     (tmr_zero_pulse),
    .go_o       (go)
  );

  assign ch_adv     = hs && !at_end;
  assign conv_start = go || ch_adv;

  sar_chan_seq #(.CH_W(CH_W)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (go),
    .adv_i    (ch_adv),
    .first_i  (cfg_first_ch),
    .last_i   (cfg_last_ch),
    .ch_o     (ch),
    .at_end_o (at_end)
  );

  sar_conv_core #(
    .RES_W      (RES_W),
    .RES_NARROW (RES_NARROW),
    .SMP_W      (SMP_W),
    .CMP_W      (CMP_W)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (conv_start),
    .res10_i     (cfg_res10),
    .smp_len_i   (cfg_smp_len),
    .cmp_len_i   (cfg_cmp_len),
    .cmp_gt_i    (cmp_gt_i),
    .res_ready_i (res_ready_i),
    .sample_o    (sh_sample_o),
    .dac_code_o  (dac_code_o),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o),
    .done_o      (done),
    .hs_o        (hs)
  );

  sar_irq_flag u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (done),
    .clr_i  (irq_clr),
    .en_i   (irq_en),
    .flag_o (irq_flag_o),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             busy_q <= 1'b0;
    else if (go)            busy_q <= 1'b1;
    else if (hs && at_end)  busy_q <= 1'b0;
  end

  assign busy_o   = busy_q;
  assign ch_sel_o = ch;
  assign res_ch_o = ch;

  AST_FLAG_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid_o) |-> irq_flag_o);  // R9
  AST_BUSY_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(res_valid_o && res_ready_i && at_end));  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!sh_sample_o && !res_valid_o));  // R10
  AST_NO_RESTART_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !res_valid_o && (sw_start || tmr_reload_pulse || tmr_zero_pulse)) |=> $stable(ch_sel_o));  // R2
endmodule

// File: tb/sar_scan_ctrl_tb.sv
module sar_scan_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_first_ch = '0;
  logic [2:0] cfg_last_ch = '0;
  logic       cfg_res10 = 1'b1;
  logic [7:0] cfg_smp_len = 8'd2;
  logic [3:0] cfg_cmp_len = 4'd1;
  logic [1:0] cfg_ext_sel = 2'b00;
  logic       sw_start = 1'b0;
  logic       tmr_reload_pulse = 1'b0;
  logic       tmr_zero_pulse = 1'b0;
  logic       irq_en = 1'b0;
  logic       irq_clr = 1'b0;
  logic       res_ready = 1'b1;
  logic       busy_o, irq_flag_o, irq_o, sh_sample_o, res_valid_o, cmp_gt;
  logic [2:0] ch_sel_o, res_ch_o;
  logic [9:0] dac_code_o, res_data_o;

  always #5 clk = ~clk;

  sar_scan_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_first_ch(cfg_first_ch), .cfg_last_ch(cfg_last_ch), .cfg_res10(cfg_res10),
    .cfg_smp_len(cfg_smp_len), .cfg_cmp_len(cfg_cmp_len), .cfg_ext_sel(cfg_ext_sel),
    .sw_start(sw_start), .tmr_reload_pulse(tmr_reload_pulse), .tmr_zero_pulse(tmr_zero_pulse),
    .irq_en(irq_en), .irq_clr(irq_clr),
    .busy_o(busy_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o),
    .ch_sel_o(ch_sel_o), .sh_sample_o(sh_sample_o), .dac_code_o(dac_code_o), .cmp_gt_i(cmp_gt),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready), .res_ch_o(res_ch_o), .res_data_o(res_data_o)
  );

  // ---------------- analog front-end model ----------------
  int ain [8];
  int held = 0;
  always @(negedge clk) if (sh_sample_o) held <= ain[ch_sel_o];
  assign cmp_gt = held > (cfg_res10 ? int'(dac_code_o) : int'(dac_code_o) * 4);

  // ---------------- bookkeeping ----------------
  int n_chk = 0;
  int n_fail = 0;
  bit done_run = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_code(input int h, input bit r10);
    if (h <= 0) return 0;
    return r10 ? (h - 1) : ((h - 1) >> 2);
  endfunction

  // ---------------- cycle reference model ----------------
  int  q[$];
  bit  busy_m = 0, valid_m = 0, flag_m = 0, set_m;
  int  t_left = 0, len_m = 0, cap_m = 0;

  function automatic int conv_len();
    return (int'(cfg_smp_len) + 1) + (cfg_res10 ? 10 : 8) * (int'(cfg_cmp_len) + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_m = 0; valid_m = 0; flag_m = 0; t_left = 0; q.delete();
    end else begin
      set_m = 0;
      if (!busy_m) begin
        if (sw_start || (cfg_ext_sel[0] && tmr_reload_pulse) || (cfg_ext_sel[1] && tmr_zero_pulse)) begin
          int c;
          c = int'(cfg_first_ch);
          q.push_back(c);
          while (c != int'(cfg_last_ch)) begin
            c = (c + 1) % 8;
            q.push_back(c);
          end
          busy_m = 1;
          len_m = conv_len(); t_left = len_m; cap_m = ain[q[0]];
        end
      end else if (valid_m) begin
        if (res_ready) begin
          void'(q.pop_front());
          valid_m = 0;
          if (q.size() == 0) busy_m = 0;
          else begin
            len_m = conv_len(); t_left = len_m; cap_m = ain[q[0]];
          end
        end
      end else begin
        t_left--;
        if (t_left == 0) begin valid_m = 1; set_m = 1; end
      end
      if (irq_clr) flag_m = 0;
      if (set_m) flag_m = 1;
    end
  end

  // ---------------- per-clock comparison ----------------
  int  res_cnt = 0;
  bit  prev_valid = 0;
  int  last_data = -1, last_ch = -1;
  int  cyc = 0;
  bit  stall_mode = 0;

  always @(negedge clk) begin
    cyc++;
    res_ready <= stall_mode ? ((cyc % 3) == 2) : 1'b1;
    if (rst_n && !done_run) begin
      chk(busy_o == busy_m, "R10 busy", busy_o, busy_m);
      chk(res_valid_o == valid_m, "R6 result timing", res_valid_o, valid_m);
      chk(irq_flag_o == flag_m, "R9 flag", irq_flag_o, flag_m);
      chk(irq_o == (flag_m && irq_en), "R9 irq gate", irq_o, flag_m && irq_en);
      if (busy_m && !valid_m)
        chk(sh_sample_o == (t_left > len_m - int'(cfg_smp_len) - 1), "R4 sample window",
            sh_sample_o, t_left > len_m - int'(cfg_smp_len) - 1);
      if (busy_m) chk(int'(ch_sel_o) == q[0], "R3 channel", ch_sel_o, q[0]);
      if (valid_m && res_valid_o) begin
        chk(int'(res_data_o) == exp_code(cap_m, cfg_res10), "R7 result", res_data_o, exp_code(cap_m, cfg_res10));
        chk(int'(res_ch_o) == q[0], "R8 result channel", res_ch_o, q[0]);
      end
      if (res_valid_o && !prev_valid) res_cnt++;
      if (res_valid_o) begin last_data = int'(res_data_o); last_ch = int'(res_ch_o); end
      prev_valid = res_valid_o;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse_sw();
    @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0;
  endtask
  task automatic pulse_reload();
    @(negedge clk); tmr_reload_pulse = 1; @(negedge clk); tmr_reload_pulse = 0;
  endtask
  task automatic pulse_zero();
    @(negedge clk); tmr_zero_pulse = 1; @(negedge clk); tmr_zero_pulse = 0;
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask
  task automatic setup(input int f, input int l, input bit r10);
    @(negedge clk);
    cfg_first_ch = 3'(f); cfg_last_ch = 3'(l); cfg_res10 = r10; res_cnt = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    for (int i = 0; i < 8; i++) ain[i] = 0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && irq_flag_o == 0 && irq_o == 0 && sh_sample_o == 0 && res_valid_o == 0 && dac_code_o == 0,
        "R11 reset state", {busy_o, irq_flag_o, res_valid_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1: unselected timer events do nothing
    cfg_ext_sel = 2'b00;
    pulse_reload(); pulse_zero(); @(negedge clk);
    chk(busy_o == 0, "R1 no ext selected", busy_o, 0);
    cfg_ext_sel = 2'b01;
    pulse_zero(); @(negedge clk);
    chk(busy_o == 0, "R1 zero pulse not selected", busy_o, 0);

    // R3/R7: 10-bit scan 2..4 by software start
    ain[2] = 100; ain[3] = 513; ain[4] = 1023;
    setup(2, 4, 1);
    pulse_sw();
    chk(busy_o == 1, "R10 busy after start", busy_o, 1);
    wait_idle();
    chk(res_cnt == 3, "R3 count 2..4", res_cnt, 3);
    chk(last_ch == 4 && last_data == 1022, "R7 full-scale 10-bit", last_data, 1022);
    chk(irq_flag_o == 1, "R9 flag sticky", irq_flag_o, 1);

    // R3 wrap, 8-bit, reload trigger, R2 extra starts ignored
    ain[6] = 0; ain[7] = 4; ain[0] = 5; ain[1] = 1000;
    setup(6, 1, 0);
    pulse_reload();
    repeat (10) @(negedge clk);
    pulse_sw(); pulse_reload();
    wait_idle();
    chk(res_cnt == 4, "R3 R2 wrap count", res_cnt, 4);
    chk(last_ch == 1 && last_data == 249, "R7 8-bit value", last_data, 249);

    // R9 clear, then R8 back-pressure on zero-detect trigger
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(irq_flag_o == 0, "R9 cleared", irq_flag_o, 0);
    irq_en = 1;
    cfg_ext_sel = 2'b10;
    ain[5] = 1;
    setup(5, 5, 1);
    stall_mode = 1;
    pulse_zero();
    wait_idle();
    stall_mode = 0;
    chk(res_cnt == 1, "R3 single channel", res_cnt, 1);
    chk(last_data == 0, "R7 near-zero input", last_data, 0);
    chk(irq_o == 1, "R9 irq enabled", irq_o, 1);

    // R5 + R6: longer timing, input disturbed during trials
    cfg_smp_len = 8'd5; cfg_cmp_len = 4'd3;
    ain[3] = 700;
    setup(3, 3, 1);
    pulse_sw();
    repeat (12) @(negedge clk);
    ain[3] = 10;
    wait_idle();
    chk(last_data == 699, "R5 held input used", last_data, 699);

    // R1 either-event selection, 8-bit full scale, multi-channel under stall
    cfg_smp_len = 8'd0; cfg_cmp_len = 4'd0;
    cfg_ext_sel = 2'b11;
    ain[0] = 1023; ain[1] = 512;
    setup(0, 1, 0);
    stall_mode = 1;
    pulse_zero();
    wait_idle();
    stall_mode = 0;
    chk(res_cnt == 2, "R1 R8 either trigger count", res_cnt, 2);
    chk(last_ch == 1 && last_data == 127, "R7 8-bit mid", last_data, 127);
    setup(0, 0, 0);
    pulse_reload();
    wait_idle();
    chk(last_data == 255, "R7 8-bit full scale", last_data, 255);

    done_run = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule